// File: doc/BRIEF.md
# Memory-to-Memory Copy Channel

This block is a single channel of a copy engine. Software fills in a start source address, a start destination address, an item count and a control word through a small register port. When it sets the start bit in software-copy mode, the channel fetches one item from the current source address and stores it at the current destination address on a simple memory master port. It repeats this until the running count reaches zero. Both running addresses advance by the item size after every stored item.

The channel checks the start addresses against the item size and refuses to begin when either is misaligned. A bus error ends the run and sets a sticky error flag. A normal finish sets a sticky done flag. The interrupt line is high while either flag is set. An optional reload copies the start registers back into the running registers at a normal finish, so the same copy can be started again without new programming. An optional lock bit keeps the bus lock output asserted for every access of a run.

Top module: `xfer_chan`

## Requirements
- R1: After reset every register reads zero, `m_req` and `m_lock` are low and `irq` is low.
- R2: The register offsets on `cfg_addr` are: 0 control, 1 start source, 2 start destination, 3 start count, 4 running source, 5 running destination, 6 running count (4 to 6 read-only). The control word holds start in bit 0, mode in bits 2:1, item size in bits 4:3, reload enable in bit 5, lock enable in bit 6, done flag in bit 8, error flag in bit 9, source misalignment in bit 10 and destination misalignment in bit 11.
- R3: Each item is a read (`m_write`=0) at the running source address, followed by a write (`m_write`=1) of the same data at the running destination address. `m_size` equals the item-size field on both accesses.
- R4: Item size 00 is a byte, 01 is a halfword, and 10 or 11 is a word. After every completed write, both running addresses advance by 1, 2 or 4 and the running count drops by one. The run ends after the write that takes the count to zero.
- R5: Control bit 10 (or 11) reads 1 exactly when the start source (or destination) address breaks the size rule: for halfword, bit 0 must be 0; for word, bits 1:0 must be 00; a byte is never misaligned.
- R6: A start request made while either misalignment flag is set causes no bus access, and the start bit returns to 0.
- R7: The done flag is set by hardware at a normal finish. A control write with bit 8 at 1 leaves it set, and a control write with bit 8 at 0 clears it.
- R8: An `m_err` response ends the run at once and sets the error flag, which clears only by a control write with bit 9 at 0. The running registers keep the values they had after the last completed item. `irq` is the OR of the done and error flags.
- R9: The start bit reads 1 while a run is in progress and clears itself when the run ends. It can only be set when the control write also selects mode 01 (software copy); with any other mode it stays 0.
- R10: With reload enabled, a normal finish loads the running source, destination and count from the start registers.
- R11: With lock enabled, `m_lock` is high on every access of the run. With lock disabled, `m_lock` stays low.
- R12: Starting with a running count of zero performs no access, sets the done flag and clears the start bit.
- R13: A write to a start register while idle also loads the matching running register. While a run is in progress, such a write changes only the start register. Writes to control fields other than the two flags are ignored during a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| m_req | output | 1 | Master access request |
| m_write | output | 1 | 1 = write access, 0 = read access |
| m_addr | output | AW | Access address |
| m_size | output | 2 | Access size code |
| m_wdata | output | DW | Write data |
| m_lock | output | 1 | Bus lock |
| m_rdata | input | DW | Read data, valid with m_ack |
| m_ack | input | 1 | Access completed |
| m_err | input | 1 | Access failed |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that the memory side answers a request only while `m_req` is high, that it answers with a one-cycle `m_ack` or `m_err` pulse, and that no two requests are answered in the same cycle. The responder in the bench is built this way: it answers each request at most once and drops its response on the next falling edge. The bench writes the start registers only while idle, except in the one case that checks a write during a run. Every run ends either with the count reaching zero or with one injected error, so a response never arrives after the run is over.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  localparam logic [1:0] MODE_SWCOPY = 2'b01;

  localparam int CB_GO    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_SIZE  = 3;
  localparam int CB_AUTO  = 5;
  localparam int CB_LOCK  = 6;
  localparam int CB_DONE  = 8;
  localparam int CB_ERR   = 9;
  localparam int CB_SMIS  = 10;
  localparam int CB_DMIS  = 11;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_SRCB  = 3'd1;
  localparam logic [2:0] OFS_DSTB  = 3'd2;
  localparam logic [2:0] OFS_CNTB  = 3'd3;
  localparam logic [2:0] OFS_SRCC  = 3'd4;
  localparam logic [2:0] OFS_DSTC  = 3'd5;
  localparam logic [2:0] OFS_CNTC  = 3'd6;

  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      2'b00:   size_step = 3'd1;
      2'b01:   size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

  function automatic logic size_misal(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'b00:   size_misal = 1'b0;
      2'b01:   size_misal = lo[0];
      default: size_misal = |lo;
    endcase
  endfunction

endpackage

// File: rtl/xfer_chan_align.sv
module xfer_chan_align #(
  parameter int NCHK = 2
) (
  input  logic [1:0]            size_i,
  input  logic [NCHK-1:0][1:0]  addr_lo_i,
  output logic [NCHK-1:0]       misal_o
);
  import xfer_pkg::*;

  for (genvar g = 0; g < NCHK; g++) begin : g_chk
    assign misal_o[g] = size_misal(size_i, addr_lo_i[g]);
  end

endmodule

// File: rtl/xfer_chan_regs.sv
module xfer_chan_regs #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int RBW = 32
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [2:0]     addr_i,
  input  logic [RBW-1:0] wdata_i,
  input  logic           busy_i,
  input  logic           done_i,
  input  logic           err_i,
  input  logic           reject_i,
  output logic           go_o,
  output logic [1:0]     mode_o,
  output logic [1:0]     size_o,
  output logic           auto_o,
  output logic           lock_o,
  output logic           done_flag_o,
  output logic           err_flag_o,
  output logic [AW-1:0]  src_base_o,
  output logic [AW-1:0]  dst_base_o,
  output logic [CW-1:0]  cnt_base_o,
  output logic           ld_src_o,
  output logic           ld_dst_o,
  output logic           ld_cnt_o
);
  import xfer_pkg::*;

  logic          go_q, go_d;
  logic [1:0]    mode_q, size_q;
  logic          auto_q, lock_q;
  logic          dflag_q, dflag_d, eflag_q, eflag_d;
  logic [AW-1:0] srcb_q, dstb_q;
  logic [CW-1:0] cntb_q;
  logic          ctrl_wr, cfg_en, srcb_en, dstb_en, cntb_en;

  always_comb begin
    ctrl_wr = we_i && (addr_i == OFS_CTRL);
    cfg_en  = ctrl_wr && !busy_i;
    srcb_en = we_i && (addr_i == OFS_SRCB);
    dstb_en = we_i && (addr_i == OFS_DSTB);
    cntb_en = we_i && (addr_i == OFS_CNTB);

    go_d = go_q;
    if (done_i || err_i || reject_i)
      go_d = 1'b0;
    else if (cfg_en && wdata_i[CB_GO] && (wdata_i[CB_MODE +: 2] == MODE_SWCOPY))
      go_d = 1'b1;

    dflag_d = dflag_q;
    if (done_i)
      dflag_d = 1'b1;
    else if (ctrl_wr && !wdata_i[CB_DONE])
      dflag_d = 1'b0;

    eflag_d = eflag_q;
    if (err_i)
      eflag_d = 1'b1;
    else if (ctrl_wr && !wdata_i[CB_ERR])
      eflag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q    <= 1'b0;
      mode_q  <= '0;
      size_q  <= '0;
      auto_q  <= 1'b0;
      lock_q  <= 1'b0;
      dflag_q <= 1'b0;
      eflag_q <= 1'b0;
      srcb_q  <= '0;
      dstb_q  <= '0;
      cntb_q  <= '0;
    end else begin
      go_q    <= go_d;
      dflag_q <= dflag_d;
      eflag_q <= eflag_d;
      if (cfg_en) begin
        mode_q <= wdata_i[CB_MODE +: 2];
        size_q <= wdata_i[CB_SIZE +: 2];
        auto_q <= wdata_i[CB_AUTO];
        lock_q <= wdata_i[CB_LOCK];
      end
      if (srcb_en) srcb_q <= wdata_i[AW-1:0];
      if (dstb_en) dstb_q <= wdata_i[AW-1:0];
      if (cntb_en) cntb_q <= wdata_i[CW-1:0];
    end
  end

  assign go_o        = go_q;
  assign mode_o      = mode_q;
  assign size_o      = size_q;
  assign auto_o      = auto_q;
  assign lock_o      = lock_q;
  assign done_flag_o = dflag_q;
  assign err_flag_o  = eflag_q;
  assign src_base_o  = srcb_q;
  assign dst_base_o  = dstb_q;
  assign cnt_base_o  = cntb_q;
  assign ld_src_o    = srcb_en && !busy_i;
  assign ld_dst_o    = dstb_en && !busy_i;
  assign ld_cnt_o    = cntb_en && !busy_i;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (dflag_q && !(ctrl_wr && !wdata_i[CB_DONE])) |=> dflag_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (eflag_q && !(ctrl_wr && !wdata_i[CB_ERR])) |=> eflag_q); // R8
  AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_i || err_i) |=> !go_q); // R9
  AST_GO_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!go_q && ctrl_wr && (wdata_i[CB_MODE +: 2] != MODE_SWCOPY)) |=> !go_q); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(size_q)); // R13

endmodule

// File: rtl/xfer_chan_engine.sv
module xfer_chan_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  parameter int RBW = 32
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic           misal_i,
  input  logic [1:0]     size_i,
  input  logic           auto_i,
  input  logic [AW-1:0]  src_base_i,
  input  logic [AW-1:0]  dst_base_i,
  input  logic [CW-1:0]  cnt_base_i,
  input  logic           ld_src_i,
  input  logic           ld_dst_i,
  input  logic           ld_cnt_i,
  input  logic [RBW-1:0] ld_val_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic           reject_o,
  output logic [AW-1:0]  src_cur_o,
  output logic [AW-1:0]  dst_cur_o,
  output logic [CW-1:0]  cnt_cur_o,
  output logic           m_req_o,
  output logic           m_write_o,
  output logic [AW-1:0]  m_addr_o,
  output logic [DW-1:0]  m_wdata_o,
  input  logic [DW-1:0]  m_rdata_i,
  input  logic           m_ack_i,
  input  logic           m_err_i
);
  import xfer_pkg::*;

  xfer_st_e      state_q, state_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] buf_q;
  logic          buf_en;
  logic          done_p, err_p, rej_p;
  logic [AW-1:0] step;

  assign step   = AW'(size_step(size_i));
  assign buf_en = (state_q == ST_RD) && m_ack_i && !m_err_i;

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cnt_d   = cnt_q;
    done_p  = 1'b0;
    err_p   = 1'b0;
    rej_p   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_src_i) src_d = ld_val_i[AW-1:0];
        if (ld_dst_i) dst_d = ld_val_i[AW-1:0];
        if (ld_cnt_i) cnt_d = ld_val_i[CW-1:0];
        if (go_i) begin
          if (misal_i)
            rej_p = 1'b1;
          else if (cnt_q == '0)
            done_p = 1'b1;
          else
            state_d = ST_RD;
        end
      end
      ST_RD: begin
        if (m_err_i) begin
          err_p   = 1'b1;
          state_d = ST_IDLE;
        end else if (m_ack_i) begin
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (m_err_i) begin
          err_p   = 1'b1;
          state_d = ST_IDLE;
        end else if (m_ack_i) begin
          src_d = src_q + step;
          dst_d = dst_q + step;
          cnt_d = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            done_p  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (done_p && auto_i) begin
      src_d = src_base_i;
      dst_d = dst_base_i;
      cnt_d = cnt_base_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cnt_q   <= cnt_d;
      if (buf_en) buf_q <= m_rdata_i;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_p;
  assign err_o     = err_p;
  assign reject_o  = rej_p;
  assign src_cur_o = src_q;
  assign dst_cur_o = dst_q;
  assign cnt_cur_o = cnt_q;
  assign m_req_o   = (state_q != ST_IDLE);
  assign m_write_o = (state_q == ST_WR);
  assign m_addr_o  = (state_q == ST_WR) ? dst_q : src_q;
  assign m_wdata_o = buf_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WR && m_ack_i && !m_err_i && cnt_q != CW'(1))
      |=> (src_q == $past(src_q) + $past(step)) && (cnt_q == $past(cnt_q) - CW'(1))); // R4
  AST_NO_START_MISAL: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && misal_i) |=> (state_q == ST_IDLE)); // R6
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_p && auto_i) |=> (cnt_q == $past(cnt_base_i)) && (src_q == $past(src_base_i))); // R10
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_ni)
    (m_req_o && m_err_i) |=> !m_req_o); // R8
  AST_ZERO_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_IDLE && cnt_q == '0) |=> !m_req_o); // R12
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_WR && $past(state_q) != ST_WR) |-> ($past(state_q) == ST_RD)); // R3

endmodule

// File: rtl/xfer_chan.sv
module xfer_chan #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          m_req,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  output logic          m_lock,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ack,
  input  logic          m_err,
  output logic          irq
);
  import xfer_pkg::*;

  localparam int RBW = 32;
  localparam int NCHK = 2;

  logic          rst_meta_q, rst_sync_q;
  logic          go, auto_en, lock_en, dflag, eflag;
  logic [1:0]    mode, size;
  logic [AW-1:0] src_base, dst_base, src_cur, dst_cur;
  logic [CW-1:0] cnt_base, cnt_cur;
  logic          ld_src, ld_dst, ld_cnt;
  logic          busy, done_p, err_p, rej_p;
  logic [NCHK-1:0][1:0] lo_bits;
  logic [NCHK-1:0] misal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  xfer_chan_regs #(.AW(AW), .CW(CW), .RBW(RBW)) u_regs (
    .clk        (clk),
    .rst_ni     (rst_sync_q),
    .we_i       (cfg_we),
    .addr_i     (cfg_addr),
    .wdata_i    (cfg_wdata),
    .busy_i     (busy),
    .done_i     (done_p),
    .err_i      (err_p),
    .reject_i   (rej_p),
    .go_o       (go),
    .mode_o     (mode),
    .size_o     (size),
    .auto_o     (auto_en),
    .lock_o     (lock_en),
    .done_flag_o(dflag),
    .err_flag_o (eflag),
    .src_base_o (src_base),
    .dst_base_o (dst_base),
    .cnt_base_o (cnt_base),
    .ld_src_o   (ld_src),
    .ld_dst_o   (ld_dst),
    .ld_cnt_o   (ld_cnt)
  );

  assign lo_bits[0] = src_base[1:0];
  assign lo_bits[1] = dst_base[1:0];

  xfer_chan_align #(.NCHK(NCHK)) u_align (
    .size_i   (size),
    .addr_lo_i(lo_bits),
    .misal_o  (misal)
  );

  xfer_chan_engine #(.AW(AW), .DW(DW), .CW(CW), .RBW(RBW)) u_eng (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .go_i      (go && (mode == MODE_SWCOPY)),
    .misal_i   (|misal),
    .size_i    (size),
    .auto_i    (auto_en),
    .src_base_i(src_base),
    .dst_base_i(dst_base),
    .cnt_base_i(cnt_base),
    .ld_src_i  (ld_src),
    .ld_dst_i  (ld_dst),
    .ld_cnt_i  (ld_cnt),
    .ld_val_i  (cfg_wdata),
    .busy_o    (busy),
    .done_o    (done_p),
    .err_o     (err_p),
    .reject_o  (rej_p),
    .src_cur_o (src_cur),
    .dst_cur_o (dst_cur),
    .cnt_cur_o (cnt_cur),
    .m_req_o   (m_req),
    .m_write_o (m_write),
    .m_addr_o  (m_addr),
    .m_wdata_o (m_wdata),
    .m_rdata_i (m_rdata),
    .m_ack_i   (m_ack),
    .m_err_i   (m_err)
  );

  assign m_size = size;
  assign m_lock = busy && lock_en;
  assign irq    = dflag || eflag;

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_CTRL: begin
        cfg_rdata[CB_GO]         = go;
        cfg_rdata[CB_MODE +: 2]  = mode;
        cfg_rdata[CB_SIZE +: 2]  = size;
        cfg_rdata[CB_AUTO]       = auto_en;
        cfg_rdata[CB_LOCK]       = lock_en;
        cfg_rdata[CB_DONE]       = dflag;
        cfg_rdata[CB_ERR]        = eflag;
        cfg_rdata[CB_SMIS]       = misal[0];
        cfg_rdata[CB_DMIS]       = misal[1];
      end
      OFS_SRCB: cfg_rdata[AW-1:0] = src_base;
      OFS_DSTB: cfg_rdata[AW-1:0] = dst_base;
      OFS_CNTB: cfg_rdata[CW-1:0] = cnt_base;
      OFS_SRCC: cfg_rdata[AW-1:0] = src_cur;
      OFS_DSTC: cfg_rdata[AW-1:0] = dst_cur;
      OFS_CNTC: cfg_rdata[CW-1:0] = cnt_cur;
      default:  cfg_rdata = '0;
    endcase
  end

  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (m_req && lock_en) |-> m_lock); // R11
  AST_LOCK_OFF: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !lock_en |-> !m_lock); // R11
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!dflag && !eflag) |-> !irq); // R8

endmodule

// File: tb/xfer_chan_tb_top.sv
`timescale 1ns/1ps
module xfer_chan_tb_top;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  size;
    logic        lock;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        m_req, m_write, m_lock, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic        m_ack, m_err;

  int errors = 0;
  int checks = 0;
  exp_t exp_q[$];
  logic [31:0] err_addr = 32'hFFFF_FFFF;

  always #2 clk = ~clk;

  xfer_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_req(m_req),
    .m_write(m_write), .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata),
    .m_lock(m_lock), .m_rdata(m_rdata), .m_ack(m_ack), .m_err(m_err), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // monitor and memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      m_ack = 1'b0; m_err = 1'b0; m_rdata = '0;
    end else if (m_ack || m_err) begin
      m_ack = 1'b0; m_err = 1'b0;
    end else if (m_req) begin
      if (exp_q.size() == 0) begin
        chk("R3", "unexpected access", m_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk("R3", "access direction", {31'd0, m_write}, {31'd0, it.wr});
        chk("R4", "access address", m_addr, it.addr);
        chk("R3", "access size", {30'd0, m_size}, {30'd0, it.size});
        chk("R11", "lock", {31'd0, m_lock}, {31'd0, it.lock});
        if (it.wr) chk("R3", "write data", m_wdata, it.data);
      end
      m_rdata = pat(m_addr);
      if (!m_write && m_addr == err_addr) m_err = 1'b1;
      else m_ack = 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    int n = 0;
    rd(3'd0, v);
    while (v[0] && n < 1000) begin
      rd(3'd0, v);
      n++;
    end
    chk(req, "start bit self-clears", {31'd0, v[0]}, 32'd0);
  endtask

  // driver: program, push expected accesses, start, then check final state
  task automatic run_xfer(input string req, input logic [31:0] src, input logic [31:0] dst,
                          input int cnt, input logic [1:0] sz, input logic au,
                          input logic lk, input int err_k);
    logic [31:0] v, st, es, ed, ec;
    int done_items;
    st = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
    done_items = cnt;
    err_addr = 32'hFFFF_FFFF;
    for (int i = 0; i < cnt; i++) begin
      logic [31:0] as;
      as = src + i * st;
      exp_q.push_back('{wr: 1'b0, addr: as, data: 32'd0, size: sz, lock: lk});
      if (i == err_k) begin
        err_addr = as;
        done_items = i;
        break;
      end
      exp_q.push_back('{wr: 1'b1, addr: dst + i * st, data: pat(as), size: sz, lock: lk});
    end
    wr(3'd0, 32'd0);
    wr(3'd1, src);
    wr(3'd2, dst);
    wr(3'd3, cnt);
    wr(3'd0, 32'h1 | (32'(2'b01) << 1) | (32'(sz) << 3) | (32'(au) << 5) | (32'(lk) << 6));
    wait_idle("R9");
    repeat (2) @(negedge clk);
    chk(req, "expected accesses drained", exp_q.size(), 32'd0);
    if (err_k >= 0 && err_k < cnt) begin
      es = src + done_items * st; ed = dst + done_items * st; ec = cnt - done_items;
    end else if (au) begin
      es = src; ed = dst; ec = cnt;
    end else begin
      es = src + cnt * st; ed = dst + cnt * st; ec = 0;
    end
    rd(3'd0, v);
    chk("R7", "done flag", {31'd0, v[8]}, {31'd0, !(err_k >= 0 && err_k < cnt)});
    chk("R8", "error flag", {31'd0, v[9]}, {31'd0, (err_k >= 0 && err_k < cnt)});
    chk("R8", "irq", {31'd0, irq}, 32'd1);
    rd(3'd4, v); chk(req, "running source", v, es);
    rd(3'd5, v); chk(req, "running destination", v, ed);
    rd(3'd6, v); chk(req, "running count", v, ec);
    err_addr = 32'hFFFF_FFFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    m_ack = 1'b0; m_err = 1'b0; m_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1", "register after reset", v, 32'd0);
    end
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R1", "m_req after reset", {31'd0, m_req}, 32'd0);
    chk("R1", "m_lock after reset", {31'd0, m_lock}, 32'd0);

    // R2/R3/R4 word copy of three items
    run_xfer("R4", 32'h0000_0100, 32'h0000_0200, 3, 2'b10, 1'b0, 1'b0, -1);
    rd(3'd1, v); chk("R2", "start source readback", v, 32'h100);
    rd(3'd3, v); chk("R2", "start count readback", v, 32'd3);

    // R7 writing 1 to done flag leaves it; writing 0 clears it
    wr(3'd0, 32'h0000_0100);
    rd(3'd0, v); chk("R7", "done kept after write 1", {31'd0, v[8]}, 32'd1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R7", "done cleared by write 0", {31'd0, v[8]}, 32'd0);
    chk("R8", "irq low with no flags", {31'd0, irq}, 32'd0);

    // R10 halfword with reload, R11 lock
    run_xfer("R10", 32'h0000_0302, 32'h0000_0402, 2, 2'b01, 1'b1, 1'b1, -1);
    chk("R11", "lock low after run", {31'd0, m_lock}, 32'd0);

    // byte copy from odd addresses, size 11 as word
    run_xfer("R4", 32'h0000_0501, 32'h0000_0603, 4, 2'b00, 1'b0, 1'b0, -1);
    run_xfer("R4", 32'h0000_0700, 32'h0000_0800, 2, 2'b11, 1'b0, 1'b0, -1);

    // R5 / R6 misalignment
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0000_0101);
    wr(3'd2, 32'h0000_0200);
    wr(3'd3, 32'd2);
    wr(3'd0, 32'h0000_0010);
    rd(3'd0, v);
    chk("R5", "source misaligned word", {30'd0, v[11:10]}, 32'd1);
    wr(3'd0, 32'h0000_0008);
    rd(3'd0, v);
    chk("R5", "odd source halfword", {30'd0, v[11:10]}, 32'd1);
    wr(3'd0, 32'h0000_0000);
    rd(3'd0, v);
    chk("R5", "byte never misaligned", {30'd0, v[11:10]}, 32'd0);
    wr(3'd1, 32'h0000_0104);
    wr(3'd2, 32'h0000_0203);
    wr(3'd0, 32'h0000_000A);
    rd(3'd0, v);
    chk("R5", "destination misaligned halfword", {30'd0, v[11:10]}, 32'd2);
    wr(3'd0, 32'h0000_0013);
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk("R6", "start refused when misaligned", {31'd0, v[0]}, 32'd0);
    chk("R6", "no done after refusal", {31'd0, v[8]}, 32'd0);
    chk("R6", "no access after refusal", {31'd0, m_req}, 32'd0);

    // R9 start ignored outside software mode
    wr(3'd2, 32'h0000_0204);
    wr(3'd0, 32'h0000_0015);
    repeat (4) @(negedge clk);
    rd(3'd0, v);
    chk("R9", "start ignored in mode 10", {31'd0, v[0]}, 32'd0);
    chk("R9", "no access in mode 10", {31'd0, m_req}, 32'd0);
    rd(3'd6, v);
    chk("R9", "count untouched in mode 10", v, 32'd2);

    // R8 bus error on third item read
    run_xfer("R8", 32'h0000_1000, 32'h0000_2000, 4, 2'b10, 1'b1, 1'b0, 2);
    wr(3'd0, 32'h0000_0200);
    rd(3'd0, v); chk("R8", "error kept after write 1", {31'd0, v[9]}, 32'd1);
    wr(3'd0, 32'h0);
    rd(3'd0, v); chk("R8", "error cleared by write 0", {31'd0, v[9]}, 32'd0);

    // R12 zero count
    wr(3'd1, 32'h0000_0040);
    wr(3'd2, 32'h0000_0080);
    wr(3'd3, 32'd0);
    wr(3'd0, 32'h0000_0013);
    wait_idle("R12");
    rd(3'd0, v);
    chk("R12", "done after zero count", {31'd0, v[8]}, 32'd1);
    chk("R12", "no access for zero count", exp_q.size(), 32'd0);

    // R13 base write during a run changes base only
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0000_0300);
    wr(3'd2, 32'h0000_0400);
    wr(3'd3, 32'd3);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back('{wr: 1'b0, addr: 32'h300 + 4 * i, data: 32'd0, size: 2'b10, lock: 1'b0});
      exp_q.push_back('{wr: 1'b1, addr: 32'h400 + 4 * i, data: pat(32'h300 + 4 * i), size: 2'b10, lock: 1'b0});
    end
    wr(3'd0, 32'h0000_0013);
    wr(3'd1, 32'h0000_0900);
    wr(3'd0, 32'h0000_0003);
    wait_idle("R13");
    rd(3'd4, v); chk("R13", "running source unaffected by busy write", v, 32'h30C);
    rd(3'd1, v); chk("R13", "start source updated by busy write", v, 32'h900);
    rd(3'd0, v); chk("R13", "size field kept during run", {30'd0, v[4:3]}, 32'd2);
    wr(3'd1, 32'h0000_0A00);
    rd(3'd4, v); chk("R13", "idle write loads running source", v, 32'hA00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule